// File: doc/BRIEF.md
# Operand Addressing Fetch Controller

This block takes a 16-bit two-operand instruction word and works out where each of its operands lives. The source operand can be a register, a memory location or a constant. The destination operand can be a register or a memory location. The block reads base registers through one register-file read port. When an addressing mode needs an extension word, the block fetches it from program memory through a synchronous read port. It writes back an auto-incremented source register through one register-file write port.

The caller loads the instruction word, together with the address of the word that follows it, by pulsing a start input. When the operands are resolved, the block raises a one-cycle done strobe. With the strobe it presents the operand kinds, their values (a register index, a memory address or a constant), the opcode nibble, the byte flag and the updated program counter. The block keeps the program counter itself for the duration of the instruction. It never reads or writes register 0 through the register file.

Three register numbers change the meaning of the ordinary modes:
- With the program counter as the base, a mode gives program-relative or immediate operands.
- With the status register as the base, a mode gives absolute addressing or the constants 4 and 8.
- With register 3 as the base, a mode gives the constants 0, 1, 2 and all-ones.

Top module: `opd_fetch_ctrl`

## Requirements
- R1: While reset is held, and whenever the block is idle, busy, done, mem_req and rf_we are all 0.
- R2: Fields are taken from fixed bit positions: opcode 15:12, source register 11:8, destination mode 7, byte flag 6, source mode 5:4, destination register 3:0. The opcode and the byte flag appear on op_o and byte_o with done.
- R3: For a general source register (not 0, 2 or 3), the source result depends on the mode:
  - Mode 0 gives kind 0 (register) with the register index as the value.
  - Mode 2 gives kind 1 (memory) with the register's contents as the address. No extension fetch and no register write take place.
- R4: For a general source register, mode 1 fetches one extension word at the current PC. It gives kind 1 with address register+extension, and the PC advances by 2.
- R5: For a general source register, mode 3 gives kind 1 at the register's contents. In the first cycle after acceptance the block writes the register back incremented by 1 for a byte operation or by 2 for a word operation. The destination phase sees the incremented value.
- R6: With register 0 as the source:
  - Mode 1 gives kind 1 at (address of the extension word)+extension.
  - Mode 3 gives kind 2 (constant) whose value is the extension word. Both of these modes advance the PC by 2.
  - Mode 2 gives kind 1 at the current PC, with no fetch.
- R7: With register 2 as the source:
  - Mode 0 gives kind 0, index 2.
  - Mode 1 fetches an extension and gives kind 1 with the extension as the address.
  - Modes 2 and 3 give kind 2 with the values 4 and 8, without a fetch.
- R8: With register 3 as the source, modes 0 to 3 give kind 2 with the values 0, 1, 2 and 0xFFFF. There is no fetch and no register write.
- R9: Destination mode 0 gives kind 0 with the register index. Destination mode 1 fetches an extension word and gives kind 1 at an address that depends on the register:
  - register 0: PC+extension
  - register 2: the extension itself
  - any other register: contents+extension
- R10: The source extension word is requested before the destination extension word. Each request goes to the current PC, each consumed word adds 2 to the PC, and pc_o shows the final PC with done.
- R11: An instruction is accepted only when the block is idle. start is ignored while busy. done is high for exactly one cycle, 3 + (number of extension words) cycles after the accepting clock edge, and the block is idle the cycle after.
- R12: The memory port is synchronous. mem_rdata is used in the cycle after mem_req, and two requests are never issued in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Accept instr and pc_in when idle |
| instr | input | 16 | Instruction word |
| pc_in | input | DW | Address of the word following the instruction |
| busy | output | 1 | An instruction is in progress |
| done | output | 1 | One-cycle strobe: results valid |
| mem_req | output | 1 | Extension word read request |
| mem_addr | output | DW | Read address (current PC) |
| mem_rdata | input | DW | Read data, valid the cycle after mem_req |
| rf_raddr | output | 4 | Register file read index |
| rf_rdata | input | DW | Register file read data (combinational) |
| rf_we | output | 1 | Register file write enable (post-increment) |
| rf_waddr | output | 4 | Register file write index |
| rf_wdata | output | DW | Register file write data |
| op_o | output | 4 | Opcode nibble of the instruction |
| byte_o | output | 1 | Byte-operation flag |
| src_kind_o | output | 2 | Source kind: 0 register, 1 memory, 2 constant |
| src_val_o | output | DW | Source register index, address or constant |
| dst_kind_o | output | 2 | Destination kind: 0 register, 1 memory |
| dst_val_o | output | DW | Destination register index or address |
| pc_o | output | DW | PC after all extension words |

## Verification
The timing of each result is fixed relative to the accepting clock edge:
- The source extension request and any post-increment write appear in the first cycle after that edge.
- A source extension adds one cycle before the destination phase, where the destination request appears.
- done follows 3 + n cycles after acceptance, where n is the number of extension words, and busy drops one cycle later.

The bench's model turns every instruction into a list of expected per-cycle records with exactly that spacing. It compares the ports against one record at each falling clock edge, including the idle cycle after done. Memory data in the bench is a fixed function of the address, so every extension value and derived address is known in advance.

// File: rtl/opd_pkg.sv
package opd_pkg;

  localparam int INSTR_W = 16;
  localparam int RIDX_W  = 4;

  typedef enum logic [1:0] {
    OPK_REG   = 2'd0,
    OPK_MEM   = 2'd1,
    OPK_CONST = 2'd2
  } opk_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_SRC  = 3'd1,
    ST_SEXT = 3'd2,
    ST_DST  = 3'd3,
    ST_DEXT = 3'd4,
    ST_DONE = 3'd5
  } st_e;

  typedef struct packed {
    logic [3:0]        op;
    logic [RIDX_W-1:0] sreg;
    logic              dmode;
    logic              byte_op;
    logic [1:0]        smode;
    logic [RIDX_W-1:0] dreg;
  } fields_t;

endpackage

// File: rtl/opd_field_split.sv
module opd_field_split
  import opd_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output fields_t            fld
);

  // Field positions are fixed by the instruction format.
  assign fld.op      = instr[15:12];
  assign fld.sreg    = instr[11:8];
  assign fld.dmode   = instr[7];
  assign fld.byte_op = instr[6];
  assign fld.smode   = instr[5:4];
  assign fld.dreg    = instr[3:0];

endmodule

// File: rtl/opd_src_resolve.sv
module opd_src_resolve
  import opd_pkg::*;
#(
  parameter int                DW     = 16,
  parameter logic [RIDX_W-1:0] PC_IDX = 4'd0,
  parameter logic [RIDX_W-1:0] SR_IDX = 4'd2,
  parameter logic [RIDX_W-1:0] CG_IDX = 4'd3
) (
  input  logic [RIDX_W-1:0] sreg,
  input  logic [1:0]        smode,
  input  logic              byte_op,
  input  logic [DW-1:0]     reg_val,
  input  logic [DW-1:0]     pc,
  input  logic [DW-1:0]     ext,
  output logic              need_ext,
  output logic              post_inc,
  output logic [DW-1:0]     inc_val,
  output opk_e              kind,
  output logic [DW-1:0]     val
);

  localparam logic [DW-1:0] INC_BYTE = DW'(1);
  localparam logic [DW-1:0] INC_WORD = DW'(2);
  localparam logic [DW-1:0] K_FOUR   = DW'(4);
  localparam logic [DW-1:0] K_EIGHT  = DW'(8);

  logic [DW-1:0] idx_val;
  assign idx_val = DW'(sreg);
  assign inc_val = reg_val + (byte_op ? INC_BYTE : INC_WORD);

  always_comb begin
    need_ext = 1'b0;
    post_inc = 1'b0;
    kind     = OPK_REG;
    val      = idx_val;
    if (sreg == CG_IDX) begin
      // constant generator register
      kind = OPK_CONST;
      case (smode)
        2'd0:    val = '0;
        2'd1:    val = DW'(1);
        2'd2:    val = DW'(2);
        default: val = '1;
      endcase
    end else if (sreg == SR_IDX) begin
      case (smode)
        2'd0: ;
        2'd1: begin
          need_ext = 1'b1;
          kind     = OPK_MEM;
          val      = ext;
        end
        2'd2: begin
          kind = OPK_CONST;
          val  = K_FOUR;
        end
        default: begin
          kind = OPK_CONST;
          val  = K_EIGHT;
        end
      endcase
    end else if (sreg == PC_IDX) begin
      case (smode)
        2'd0: ;
        2'd1: begin
          need_ext = 1'b1;
          kind     = OPK_MEM;
          val      = pc + ext;
        end
        2'd2: begin
          kind = OPK_MEM;
          val  = pc;
        end
        default: begin
          need_ext = 1'b1;
          kind     = OPK_CONST;
          val      = ext;
        end
      endcase
    end else begin
      case (smode)
        2'd0: ;
        2'd1: begin
          need_ext = 1'b1;
          kind     = OPK_MEM;
          val      = reg_val + ext;
        end
        2'd2: begin
          kind = OPK_MEM;
          val  = reg_val;
        end
        default: begin
          kind     = OPK_MEM;
          val      = reg_val;
          post_inc = 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/opd_dst_resolve.sv
module opd_dst_resolve
  import opd_pkg::*;
#(
  parameter int                DW     = 16,
  parameter logic [RIDX_W-1:0] PC_IDX = 4'd0,
  parameter logic [RIDX_W-1:0] SR_IDX = 4'd2
) (
  input  logic [RIDX_W-1:0] dreg,
  input  logic              dmode,
  input  logic [DW-1:0]     reg_val,
  input  logic [DW-1:0]     pc,
  input  logic [DW-1:0]     ext,
  output logic              need_ext,
  output opk_e              kind,
  output logic [DW-1:0]     val
);

  always_comb begin
    need_ext = dmode;
    kind     = OPK_REG;
    val      = DW'(dreg);
    if (dmode) begin
      kind = OPK_MEM;
      if (dreg == PC_IDX)      val = pc + ext;
      else if (dreg == SR_IDX) val = ext;
      else                     val = reg_val + ext;
    end
  end

endmodule

// File: rtl/opd_fetch_ctrl.sv
module opd_fetch_ctrl
  import opd_pkg::*;
#(
  parameter int                DW      = 16,
  parameter int                PC_STEP = 2,
  parameter logic [RIDX_W-1:0] PC_IDX  = 4'd0,
  parameter logic [RIDX_W-1:0] SR_IDX  = 4'd2,
  parameter logic [RIDX_W-1:0] CG_IDX  = 4'd3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [INSTR_W-1:0] instr,
  input  logic [DW-1:0]      pc_in,
  output logic               busy,
  output logic               done,
  output logic               mem_req,
  output logic [DW-1:0]      mem_addr,
  input  logic [DW-1:0]      mem_rdata,
  output logic [RIDX_W-1:0]  rf_raddr,
  input  logic [DW-1:0]      rf_rdata,
  output logic               rf_we,
  output logic [RIDX_W-1:0]  rf_waddr,
  output logic [DW-1:0]      rf_wdata,
  output logic [3:0]         op_o,
  output logic               byte_o,
  output logic [1:0]         src_kind_o,
  output logic [DW-1:0]      src_val_o,
  output logic [1:0]         dst_kind_o,
  output logic [DW-1:0]      dst_val_o,
  output logic [DW-1:0]      pc_o
);

  localparam logic [DW-1:0] STEP = DW'(PC_STEP);

  st_e           state_q, state_d;
  fields_t       fld_q, fld_in;
  logic [DW-1:0] pc_q, pc_d, base_q;
  opk_e          src_kind_q, dst_kind_q;
  logic [DW-1:0] src_val_q, dst_val_q;

  logic fld_en, pc_en, base_en, src_en, dst_en;

  logic          s_need, s_pinc;
  logic [DW-1:0] s_newv, s_val, s_regv;
  opk_e          s_kind;
  logic          d_need;
  logic [DW-1:0] d_val, d_regv;
  opk_e          d_kind;

  // Extension cycles use the base captured in the preceding read cycle.
  assign s_regv = (state_q == ST_SEXT) ? base_q : rf_rdata;
  assign d_regv = (state_q == ST_DEXT) ? base_q : rf_rdata;

  opd_field_split u_split (
    .instr (instr),
    .fld   (fld_in)
  );

  opd_src_resolve #(
    .DW(DW), .PC_IDX(PC_IDX), .SR_IDX(SR_IDX), .CG_IDX(CG_IDX)
  ) u_src (
    .sreg     (fld_q.sreg),
    .smode    (fld_q.smode),
    .byte_op  (fld_q.byte_op),
    .reg_val  (s_regv),
    .pc       (pc_q),
    .ext      (mem_rdata),
    .need_ext (s_need),
    .post_inc (s_pinc),
    .inc_val  (s_newv),
    .kind     (s_kind),
    .val      (s_val)
  );

  opd_dst_resolve #(
    .DW(DW), .PC_IDX(PC_IDX), .SR_IDX(SR_IDX)
  ) u_dst (
    .dreg     (fld_q.dreg),
    .dmode    (fld_q.dmode),
    .reg_val  (d_regv),
    .pc       (pc_q),
    .ext      (mem_rdata),
    .need_ext (d_need),
    .kind     (d_kind),
    .val      (d_val)
  );

  // Next state and enables
  always_comb begin
    state_d  = state_q;
    pc_d     = pc_q + STEP;
    fld_en   = 1'b0;
    pc_en    = 1'b0;
    base_en  = 1'b0;
    src_en   = 1'b0;
    dst_en   = 1'b0;
    mem_req  = 1'b0;
    rf_we    = 1'b0;
    rf_raddr = fld_q.sreg;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          fld_en  = 1'b1;
          pc_en   = 1'b1;
          pc_d    = pc_in;
          state_d = ST_SRC;
        end
      end
      ST_SRC: begin
        base_en = 1'b1;
        rf_we   = s_pinc;
        if (s_need) begin
          mem_req = 1'b1;
          state_d = ST_SEXT;
        end else begin
          src_en  = 1'b1;
          state_d = ST_DST;
        end
      end
      ST_SEXT: begin
        src_en  = 1'b1;
        pc_en   = 1'b1;
        state_d = ST_DST;
      end
      ST_DST: begin
        rf_raddr = fld_q.dreg;
        base_en  = 1'b1;
        if (d_need) begin
          mem_req = 1'b1;
          state_d = ST_DEXT;
        end else begin
          dst_en  = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_DEXT: begin
        dst_en  = 1'b1;
        pc_en   = 1'b1;
        state_d = ST_DONE;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      fld_q      <= '0;
      pc_q       <= '0;
      base_q     <= '0;
      src_kind_q <= OPK_REG;
      src_val_q  <= '0;
      dst_kind_q <= OPK_REG;
      dst_val_q  <= '0;
    end else begin
      state_q <= state_d;
      if (fld_en)  fld_q  <= fld_in;
      if (pc_en)   pc_q   <= pc_d;
      if (base_en) base_q <= rf_rdata;
      if (src_en) begin
        src_kind_q <= s_kind;
        src_val_q  <= s_val;
      end
      if (dst_en) begin
        dst_kind_q <= d_kind;
        dst_val_q  <= d_val;
      end
    end
  end

  assign busy       = (state_q != ST_IDLE);
  assign done       = (state_q == ST_DONE);
  assign mem_addr   = pc_q;
  assign rf_waddr   = fld_q.sreg;
  assign rf_wdata   = s_newv;
  assign op_o       = fld_q.op;
  assign byte_o     = fld_q.byte_op;
  assign src_kind_o = src_kind_q;
  assign src_val_o  = src_val_q;
  assign dst_kind_o = dst_kind_q;
  assign dst_val_o  = dst_val_q;
  assign pc_o       = pc_q;

endmodule

// File: rtl/opd_fetch_chk.sv
module opd_fetch_chk #(
  parameter logic [3:0] PC_IDX = 4'd0,
  parameter logic [3:0] SR_IDX = 4'd2,
  parameter logic [3:0] CG_IDX = 4'd3
) (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       mem_req,
  input logic       rf_we,
  input logic [3:0] rf_waddr,
  input logic [1:0] dst_kind_o
);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !rf_we && !done));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R11
  done_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  // R12
  req_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // R5
  wr_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (rf_waddr != PC_IDX && rf_waddr != SR_IDX && rf_waddr != CG_IDX));

  // R5
  wr_no_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> !mem_req);

  // R9
  dst_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (dst_kind_o != 2'd2 && dst_kind_o != 2'd3));

endmodule

bind opd_fetch_ctrl opd_fetch_chk #(
  .PC_IDX(PC_IDX), .SR_IDX(SR_IDX), .CG_IDX(CG_IDX)
) u_opd_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .mem_req    (mem_req),
  .rf_we      (rf_we),
  .rf_waddr   (rf_waddr),
  .dst_kind_o (dst_kind_o)
);

// File: tb/opd_fetch_ctrl_tb_top.sv
`timescale 1ns/1ps
module opd_fetch_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic [15:0] pc_in = '0;
  logic        busy, done, mem_req, rf_we, byte_o;
  logic [15:0] mem_addr, mem_rdata, rf_rdata, rf_wdata;
  logic [3:0]  rf_raddr, rf_waddr, op_o;
  logic [1:0]  src_kind_o, dst_kind_o;
  logic [15:0] src_val_o, dst_val_o, pc_o;

  logic [15:0] rf [16];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct packed {
    logic        busy;
    logic        done;
    logic        mreq;
    logic [15:0] maddr;
    logic        we;
    logic [3:0]  waddr;
    logic [15:0] wdata;
    logic [1:0]  sk;
    logic [15:0] sv;
    logic [1:0]  dk;
    logic [15:0] dv;
    logic [15:0] pc;
    logic [3:0]  op;
    logic        bw;
  } rec_t;

  always #2.5 clk = ~clk;

  function automatic logic [15:0] ext_of(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h2C5B;
  endfunction

  function automatic logic [15:0] mk(input int op, input int s, input int ad,
                                     input int bw, input int m, input int d);
    return {4'(op), 4'(s), 1'(ad), 1'(bw), 2'(m), 4'(d)};
  endfunction

  // Environment: register file and synchronous program memory
  assign rf_rdata = rf[rf_raddr];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 16; k++) rf[k] <= 16'h1000 + 16'(k) * 16'h0111;
      mem_rdata <= '0;
    end else begin
      if (rf_we) rf[rf_waddr] <= rf_wdata;
      if (mem_req) mem_rdata <= ext_of(mem_addr);
    end
  end

  opd_fetch_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pc_in(pc_in),
    .busy(busy), .done(done), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .rf_raddr(rf_raddr), .rf_rdata(rf_rdata),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .op_o(op_o),
    .byte_o(byte_o), .src_kind_o(src_kind_o), .src_val_o(src_val_o),
    .dst_kind_o(dst_kind_o), .dst_val_o(dst_val_o), .pc_o(pc_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic cmp(input rec_t e, input string tag);
    chk(busy == e.busy, tag, "busy", 16'(busy), 16'(e.busy));
    chk(done == e.done, tag, "done", 16'(done), 16'(e.done));
    chk(mem_req == e.mreq, tag, "mem_req", 16'(mem_req), 16'(e.mreq));
    if (e.mreq) chk(mem_addr == e.maddr, tag, "mem_addr", mem_addr, e.maddr);
    chk(rf_we == e.we, tag, "rf_we", 16'(rf_we), 16'(e.we));
    if (e.we) begin
      chk(rf_waddr == e.waddr, tag, "rf_waddr", 16'(rf_waddr), 16'(e.waddr));
      chk(rf_wdata == e.wdata, tag, "rf_wdata", rf_wdata, e.wdata);
    end
    if (e.done) begin
      chk(src_kind_o == e.sk, tag, "src_kind", 16'(src_kind_o), 16'(e.sk));
      chk(src_val_o == e.sv, tag, "src_val", src_val_o, e.sv);
      chk(dst_kind_o == e.dk, tag, "dst_kind", 16'(dst_kind_o), 16'(e.dk));
      chk(dst_val_o == e.dv, tag, "dst_val", dst_val_o, e.dv);
      chk(pc_o == e.pc, tag, "pc_o", pc_o, e.pc);
      chk(op_o == e.op, tag, "op_o", 16'(op_o), 16'(e.op));
      chk(byte_o == e.bw, tag, "byte_o", 16'(byte_o), 16'(e.bw));
    end
  endtask

  // Behavioural model: builds the expected trace, then compares per cycle.
  task automatic run_op(input logic [15:0] ins, input logic [15:0] pc0,
                        input string tag, input bit poke);
    logic [15:0] r [16];
    rec_t q[$];
    rec_t e, idle;
    logic [3:0]  s, d;
    logic [1:0]  m;
    bit          ad, bw, sx, pinc;
    logic [15:0] p, nv, ev;
    logic [1:0]  sk, dk;
    logic [15:0] sv, dv;
    for (int k = 0; k < 16; k++) r[k] = rf[k];
    s = ins[11:8]; d = ins[3:0]; m = ins[5:4]; ad = ins[7]; bw = ins[6];
    p = pc0; sx = 0; pinc = 0; nv = '0; sk = 2'd0; sv = {12'h0, s};
    if (s == 4'd3) begin
      sk = 2'd2;
      sv = (m == 2'd3) ? 16'hFFFF : {14'h0, m};
    end else if (s == 4'd2) begin
      if (m == 2'd1) begin sx = 1; sk = 2'd1; sv = ext_of(p); end
      else if (m == 2'd2) begin sk = 2'd2; sv = 16'd4; end
      else if (m == 2'd3) begin sk = 2'd2; sv = 16'd8; end
    end else if (s == 4'd0) begin
      if (m == 2'd1) begin sx = 1; sk = 2'd1; sv = p + ext_of(p); end
      else if (m == 2'd2) begin sk = 2'd1; sv = p; end
      else if (m == 2'd3) begin sx = 1; sk = 2'd2; sv = ext_of(p); end
    end else begin
      if (m == 2'd1) begin sx = 1; sk = 2'd1; sv = r[s] + ext_of(p); end
      else if (m != 2'd0) begin
        sk = 2'd1; sv = r[s];
        if (m == 2'd3) begin pinc = 1; nv = r[s] + (bw ? 16'd1 : 16'd2); end
      end
    end
    idle = '0;
    e = '0; e.busy = 1; e.mreq = sx; e.maddr = p; e.we = pinc; e.waddr = s; e.wdata = nv;
    q.push_back(e);
    if (pinc) r[s] = nv;
    if (sx) begin
      e = '0; e.busy = 1; q.push_back(e);
      p = p + 16'd2;
    end
    dk = 2'd0; dv = {12'h0, d};
    e = '0; e.busy = 1; e.mreq = ad; e.maddr = p; q.push_back(e);
    if (ad) begin
      ev = ext_of(p);
      dk = 2'd1;
      dv = (d == 4'd0) ? p + ev : (d == 4'd2) ? ev : r[d] + ev;
      e = '0; e.busy = 1; q.push_back(e);
      p = p + 16'd2;
    end
    e = '0; e.busy = 1; e.done = 1; e.sk = sk; e.sv = sv; e.dk = dk; e.dv = dv;
    e.pc = p; e.op = ins[15:12]; e.bw = bw;
    q.push_back(e);

    @(negedge clk);
    start = 1'b1; instr = ins; pc_in = pc0;
    foreach (q[i]) begin
      @(negedge clk);
      if (i == 0 && poke) begin
        start = 1'b1; instr = 16'hFFFF; pc_in = 16'hDEAD;
      end else begin
        start = 1'b0;
      end
      cmp(q[i], tag);
    end
    @(negedge clk);
    start = 1'b0;
    cmp(idle, "R11");
  endtask

  initial begin
    rec_t z;
    z = '0;
    repeat (3) @(negedge clk);
    cmp(z, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    cmp(z, "R1");

    run_op(mk(4, 5, 0, 0, 0, 6), 16'h0200, "R2", 0);
    run_op(mk(5, 7, 0, 1, 2, 1), 16'h0300, "R3", 0);
    run_op(mk(6, 4, 1, 0, 1, 9), 16'h0400, "R4", 0);
    run_op(mk(7, 8, 0, 0, 3, 10), 16'h0500, "R5", 0);
    run_op(mk(7, 8, 0, 1, 3, 10), 16'h0502, "R5", 0);
    run_op(mk(15, 9, 1, 0, 3, 9), 16'h0510, "R5", 0);
    run_op(mk(8, 0, 0, 0, 1, 5), 16'h0600, "R6", 0);
    run_op(mk(8, 0, 0, 0, 3, 5), 16'h0610, "R6", 0);
    run_op(mk(8, 0, 0, 0, 2, 5), 16'h0620, "R6", 0);
    for (int mm = 0; mm < 4; mm++) run_op(mk(9, 2, 0, 0, mm, 4), 16'h0700, "R7", 0);
    for (int mm = 0; mm < 4; mm++) run_op(mk(10, 3, 0, 0, mm, 4), 16'h0800, "R8", 0);
    run_op(mk(11, 5, 1, 0, 0, 0), 16'h0900, "R9", 0);
    run_op(mk(11, 5, 1, 0, 0, 2), 16'h0910, "R9", 0);
    run_op(mk(11, 5, 1, 0, 0, 11), 16'h0920, "R9", 0);
    run_op(mk(12, 0, 1, 0, 3, 2), 16'h0A00, "R10", 0);
    run_op(mk(13, 0, 1, 0, 1, 0), 16'h0A40, "R10", 0);
    run_op(mk(14, 6, 0, 0, 2, 7), 16'h0B00, "R11", 1);
    run_op(mk(4, 12, 1, 1, 1, 13), 16'hFFF0, "R12", 0);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R11 watchdog actual=hung expected=complete");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule